// File: doc/BRIEF.md
# Packet Discard Error Status Unit

This unit sits beside a camera-interface receiver and records why incoming packets were thrown away. The receiver raises one pulse per dropped packet on one of four discard causes: the receive FIFO ran out of room, the packet exceeded its length limit, no channel matched its virtual channel and data type, or the matching channel was not active. Each pulse carries the virtual channel (VC) and data type (DT) of the dropped packet. For each cause the unit keeps a register holding a saturating count of drops together with the VC and DT of the most recent one.

The unit also holds a shared status register. It collects the per-channel frame and line events of four capture channels, grouped by event type, plus a general overflow flag and one flag per discard cause. Software clears a status bit by writing a one to it. A five-bit mask selects which of the error flags drive the single interrupt output. All registers are reached through a simple address/data port with a combinational read path.

Top module: `drop_status_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A pulse on `dropEvt[c]` raises the count of cause c by one and leaves the other causes unchanged. Cause indices are 0 FIFO overflow (register 0x008), 1 length limit (0x014), 2 unmatched (0x010), 3 inactive channel (0x00C). Pulses of several causes in one cycle each count.
- R3: A discard register reads as count in bits 23:0, DT in bits 29:24 and VC in bits 31:30. VC and DT always show the packet of the latest pulse of that cause.
- R4: The count stops at 0xFFFFFF. Further pulses leave it there and still update VC and DT.
- R5: A write to a discard register loads the written word, so writing zero clears it. A pulse in the same cycle as the write counts on top of the written count and overrides its VC and DT.
- R6: Status bit positions for channel x (0 to 3): frame start x, frame end 4+x, frame-end acknowledge 8+x, line end 12+x, line-end acknowledge 16+x. General overflow is bit 20. The discard flags for causes 0 to 3 are bits 21 to 24. Bits 31:25 read zero. Each event sets its bit one cycle after the pulse.
- R7: Writing the status register clears the bits written as one and leaves the bits written as zero. Bits are never cleared otherwise.
- R8: When an event and a clearing write hit the same status bit in one cycle, the bit ends set.
- R9: The mask register at 0x020 holds bits 0 to 4, enabling general overflow, then discard causes 0 to 3. Its bits 31:5 read zero.
- R10: `irq` is high exactly when some status bit 20+i and mask bit i are both set. Channel event bits never drive it.
- R11: Reads of an unmapped address return zero, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe for `regWdata` at `regAddr` |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| frameStart | input | 4 | Per-channel frame start pulses |
| frameEnd | input | 4 | Per-channel frame end pulses |
| frameEndAck | input | 4 | Per-channel frame-end acknowledge pulses |
| lineEnd | input | 4 | Per-channel line end pulses |
| lineEndAck | input | 4 | Per-channel line-end acknowledge pulses |
| ovflEvt | input | 1 | General overflow pulse |
| dropEvt | input | 4 | Discard pulses, one per cause |
| dropVc | input | 8 | VC of each cause's dropped packet, 2 bits per cause |
| dropDt | input | 24 | DT of each cause's dropped packet, 6 bits per cause |
| irq | output | 1 | Masked error interrupt |

## Verification
Two collisions matter here. The first is a hardware set meeting a software clear. The bench writes all ones to the status register in the same cycle that a channel event and a discard pulse arrive. It then expects only those two fresh bits to remain. The second is a counter write meeting a discard pulse. A count of 5 is written while a pulse of that cause arrives, and the bench expects a count of 6 carrying the pulse's VC and DT. All other expected values come from an arithmetic model that sweeps every cause against every VC and a spread of DT values, walks all twenty channel bits, and pairs each mask bit with each error flag.

// File: rtl/drop_status_pkg.sv
package drop_status_pkg;

  localparam int NUM_CAT = 4;
  localparam int CAT_W   = $clog2(NUM_CAT);

  // cause indices; order fixes status bits 21.. and mask bits 1..
  localparam int CAT_FIFO = 0;
  localparam int CAT_LEN  = 1;
  localparam int CAT_UNM  = 2;
  localparam int CAT_IDLE = 3;

  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_MASK   = 8'h20;

  function automatic logic [7:0] catAddr(input int cat);
    case (cat)
      CAT_FIFO: catAddr = 8'h08;
      CAT_IDLE: catAddr = 8'h0C;
      CAT_UNM:  catAddr = 8'h10;
      default:  catAddr = 8'h14;
    endcase
  endfunction

  typedef enum logic [1:0] {RD_NONE, RD_STATUS, RD_MASK, RD_DROP} rdSel_e;

  typedef struct packed {
    logic               statusWr;
    logic               maskWr;
    logic [NUM_CAT-1:0] dropWr;
    rdSel_e             rdSel;
    logic [CAT_W-1:0]   rdCat;
  } regStb_t;

endpackage

// File: rtl/drop_status_ctrl.sv
module drop_status_ctrl
  import drop_status_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStb_t           stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      stb.rdSel    = RD_STATUS;
      stb.statusWr = regWrEn;
    end else if (regAddr == ADDR_W'(ADDR_MASK)) begin
      stb.rdSel  = RD_MASK;
      stb.maskWr = regWrEn;
    end else begin
      for (int c = 0; c < NUM_CAT; c++) begin
        if (regAddr == ADDR_W'(catAddr(c))) begin
          stb.rdSel     = RD_DROP;
          stb.rdCat     = CAT_W'(c);
          stb.dropWr[c] = regWrEn;
        end
      end
    end
  end

endmodule

// File: rtl/drop_count_cell.sv
module drop_count_cell #(
  parameter int AMT_W = 24,
  parameter int DT_W  = 6,
  parameter int VC_W  = 2,
  localparam int REG_W = AMT_W + DT_W + VC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  input  logic [VC_W-1:0]  evtVc,
  input  logic [DT_W-1:0]  evtDt,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regVal
);

  localparam logic [AMT_W-1:0] AMT_MAX = {AMT_W{1'b1}};

  logic [AMT_W-1:0] amt, baseAmt, nextAmt;
  logic [DT_W-1:0]  dt, baseDt, nextDt;
  logic [VC_W-1:0]  vc, baseVc, nextVc;

  always_comb begin
    baseAmt = wrEn ? wrData[AMT_W-1:0]           : amt;
    baseDt  = wrEn ? wrData[AMT_W +: DT_W]       : dt;
    baseVc  = wrEn ? wrData[AMT_W+DT_W +: VC_W]  : vc;
    nextAmt = (evt && baseAmt != AMT_MAX) ? baseAmt + 1'b1 : baseAmt;
    nextDt  = evt ? evtDt : baseDt;
    nextVc  = evt ? evtVc : baseVc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      amt <= '0;
      dt  <= '0;
      vc  <= '0;
    end else begin
      amt <= nextAmt;
      dt  <= nextDt;
      vc  <= nextVc;
    end
  end

  assign regVal = {vc, dt, amt};

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (amt == AMT_MAX && !wrEn) |=> amt == AMT_MAX);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evt && !wrEn) |=> $stable(regVal));

  // R3
  last_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> (vc == $past(evtVc) && dt == $past(evtDt)));

endmodule

// File: rtl/drop_status_dp.sv
module drop_status_dp
  import drop_status_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMT_W  = 24,
  parameter int DT_W   = 6,
  parameter int VC_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStb_t                  stb,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  input  logic [NUM_CH-1:0]        frameStart,
  input  logic [NUM_CH-1:0]        frameEnd,
  input  logic [NUM_CH-1:0]        frameEndAck,
  input  logic [NUM_CH-1:0]        lineEnd,
  input  logic [NUM_CH-1:0]        lineEndAck,
  input  logic                     ovflEvt,
  input  logic [NUM_CAT-1:0]       dropEvt,
  input  logic [NUM_CAT*VC_W-1:0]  dropVc,
  input  logic [NUM_CAT*DT_W-1:0]  dropDt,
  output logic                     irq
);

  localparam int CH_BITS  = 5 * NUM_CH;
  localparam int ERR_BITS = 1 + NUM_CAT;
  localparam int STAT_W   = CH_BITS + ERR_BITS;
  localparam int DROP_W   = AMT_W + DT_W + VC_W;

  logic [STAT_W-1:0]   status, setVec, clrVec;
  logic [ERR_BITS-1:0] mask;
  logic [DROP_W-1:0]   dropRegs [NUM_CAT];

  // events packed by type, lowest type first
  assign setVec = {dropEvt, ovflEvt, lineEndAck, lineEnd, frameEndAck, frameEnd, frameStart};
  assign clrVec = stb.statusWr ? regWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (stb.maskWr) mask <= regWdata[ERR_BITS-1:0];
    end
  end

  assign irq = |(status[STAT_W-1:CH_BITS] & mask);

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    drop_count_cell #(
      .AMT_W (AMT_W),
      .DT_W  (DT_W),
      .VC_W  (VC_W)
    ) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .evt    (dropEvt[c]),
      .evtVc  (dropVc[c*VC_W +: VC_W]),
      .evtDt  (dropDt[c*DT_W +: DT_W]),
      .wrEn   (stb.dropWr[c]),
      .wrData (regWdata[DROP_W-1:0]),
      .regVal (dropRegs[c])
    );
  end

  always_comb begin
    case (stb.rdSel)
      RD_STATUS: regRdata = DATA_W'(status);
      RD_MASK:   regRdata = DATA_W'(mask);
      RD_DROP:   regRdata = DATA_W'(dropRegs[stb.rdCat]);
      default:   regRdata = '0;
    endcase
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((status & $past(setVec)) == $past(setVec)));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.statusWr |=> ((status & $past(status)) == $past(status)));

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.statusWr, stb.maskWr, stb.dropWr}));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !(|setVec[STAT_W-1:CH_BITS]) && !stb.maskWr) |=> !irq);

endmodule

// File: rtl/drop_status_unit.sv
module drop_status_unit
  import drop_status_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMT_W  = 24,
  parameter int DT_W   = 6,
  parameter int VC_W   = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  input  logic [NUM_CH-1:0]       frameStart,
  input  logic [NUM_CH-1:0]       frameEnd,
  input  logic [NUM_CH-1:0]       frameEndAck,
  input  logic [NUM_CH-1:0]       lineEnd,
  input  logic [NUM_CH-1:0]       lineEndAck,
  input  logic                    ovflEvt,
  input  logic [NUM_CAT-1:0]      dropEvt,
  input  logic [NUM_CAT*VC_W-1:0] dropVc,
  input  logic [NUM_CAT*DT_W-1:0] dropDt,
  output logic                    irq
);

  regStb_t stb;

  drop_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  drop_status_dp #(
    .NUM_CH (NUM_CH),
    .AMT_W  (AMT_W),
    .DT_W   (DT_W),
    .VC_W   (VC_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .frameStart  (frameStart),
    .frameEnd    (frameEnd),
    .frameEndAck (frameEndAck),
    .lineEnd     (lineEnd),
    .lineEndAck  (lineEndAck),
    .ovflEvt     (ovflEvt),
    .dropEvt     (dropEvt),
    .dropVc      (dropVc),
    .dropDt      (dropDt),
    .irq         (irq)
  );

endmodule

// File: tb/tb_drop_status_unit.sv
module tb_drop_status_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [19:0] chanAll = '0;
  logic        ovflEvt = 1'b0;
  logic [3:0]  dropEvt = '0;
  logic [7:0]  dropVc = '0;
  logic [23:0] dropDt = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  drop_status_unit dut (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .frameStart  (chanAll[3:0]),
    .frameEnd    (chanAll[7:4]),
    .frameEndAck (chanAll[11:8]),
    .lineEnd     (chanAll[15:12]),
    .lineEndAck  (chanAll[19:16]),
    .ovflEvt     (ovflEvt),
    .dropEvt     (dropEvt),
    .dropVc      (dropVc),
    .dropDt      (dropDt),
    .irq         (irq)
  );

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] expDrop [4];
  logic [24:0] expStat = '0;
  logic [4:0]  expMask = '0;

  function automatic logic [7:0] addrOf(input int c);
    case (c)
      0:       addrOf = 8'h08;
      1:       addrOf = 8'h14;
      2:       addrOf = 8'h10;
      default: addrOf = 8'h0C;
    endcase
  endfunction

  function automatic logic expIrq();
    expIrq = |(expStat[24:20] & expMask);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic chkReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    readReg(a, d);
    check(tag, d, exp);
  endtask

  task automatic chkAll(input string tag);
    for (int c = 0; c < 4; c++) chkReg(tag, addrOf(c), expDrop[c]);
    chkReg(tag, 8'h00, 32'(expStat));
    chkReg(tag, 8'h20, 32'(expMask));
    check({tag, " irq"}, 32'(irq), 32'(expIrq()));
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 8'h00) expStat = expStat & ~d[24:0];
    else if (a == 8'h20) expMask = d[4:0];
    else for (int c = 0; c < 4; c++) if (a == addrOf(c)) expDrop[c] = d;
  endtask

  function automatic logic [31:0] bump(input logic [31:0] r, input int vc, input int dt);
    logic [23:0] amt;
    amt = r[23:0];
    if (amt != 24'hFFFFFF) amt = amt + 1'b1;
    bump = {2'(vc), 6'(dt), amt};
  endfunction

  task automatic fireDrop(input int c, input int vc, input int dt);
    @(negedge clk);
    dropEvt[c] = 1'b1;
    dropVc[c*2 +: 2] = 2'(vc);
    dropDt[c*6 +: 6] = 6'(dt);
    @(negedge clk);
    dropEvt = '0;
    expDrop[c] = bump(expDrop[c], vc, dt);
    expStat[21+c] = 1'b1;
  endtask

  task automatic fireChan(input int b);
    @(negedge clk);
    chanAll[b] = 1'b1;
    @(negedge clk);
    chanAll = '0;
    expStat[b] = 1'b1;
  endtask

  task automatic fireOvf();
    @(negedge clk);
    ovflEvt = 1'b1;
    @(negedge clk);
    ovflEvt = 1'b0;
    expStat[20] = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R1: actual run still busy, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 4; c++) expDrop[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chkAll("R1");

    // R9: mask write, upper bits read zero
    doWrite(8'h20, 32'hFFFF_FFFF);
    chkReg("R9 mask readback", 8'h20, 32'h0000_001F);

    // R2 / R3: sweep causes x VC x DT
    for (int c = 0; c < 4; c++) begin
      for (int vc = 0; vc < 4; vc++) begin
        for (int k = 0; k < 4; k++) begin
          int dt;
          dt = (c * 13 + vc * 7 + k * 17) % 64;
          fireDrop(c, vc, dt);
          for (int o = 0; o < 4; o++) chkReg("R2 counts", addrOf(o), expDrop[o]);
          readReg(addrOf(c), d);
          check("R3 vc field", 32'(d[31:30]), 32'(vc));
          check("R3 dt field", 32'(d[29:24]), 32'(dt));
        end
      end
    end
    check("R3 count after sweep", 32'(expDrop[1][23:0]), 32'd16);
    chkAll("R6 discard flags");

    // R2: all causes in one cycle
    @(negedge clk);
    dropEvt = 4'hF; dropVc = 8'b11_10_01_00; dropDt = {6'd40, 6'd30, 6'd20, 6'd10};
    @(negedge clk);
    dropEvt = '0;
    for (int c = 0; c < 4; c++) expDrop[c] = bump(expDrop[c], c, 10 * (c + 1));
    chkAll("R2 simultaneous");

    // R5: writing zero clears
    for (int c = 0; c < 4; c++) doWrite(addrOf(c), 32'h0);
    chkAll("R5 clear");

    // R5: write with pulse in same cycle
    @(negedge clk);
    regAddr = addrOf(1); regWdata = 32'h0000_0005; regWrEn = 1'b1;
    dropEvt[1] = 1'b1; dropVc[3:2] = 2'd2; dropDt[11:6] = 6'h2A;
    @(negedge clk);
    regWrEn = 1'b0; dropEvt = '0;
    expDrop[1] = {2'd2, 6'h2A, 24'd6};
    expStat[22] = 1'b1;
    chkReg("R5 write plus pulse", addrOf(1), expDrop[1]);

    // R4: saturation
    doWrite(addrOf(2), 32'h00FF_FFFE);
    fireDrop(2, 1, 5);
    chkReg("R4 reach max", addrOf(2), {2'd1, 6'd5, 24'hFFFFFF});
    fireDrop(2, 3, 9);
    chkReg("R4 stay max", addrOf(2), {2'd3, 6'd9, 24'hFFFFFF});

    // R7: clear everything
    doWrite(8'h00, 32'hFFFF_FFFF);
    chkAll("R7 clear all");

    // R6 / R7 / R10: channel bit walk
    for (int b = 0; b < 20; b++) begin
      fireChan(b);
      chkReg("R6 channel bit", 8'h00, 32'(1) << b);
      check("R10 channel no irq", 32'(irq), 32'd0);
      doWrite(8'h00, 32'h0);
      chkReg("R7 zero write keeps", 8'h00, 32'(1) << b);
      doWrite(8'h00, 32'(1) << b);
      chkReg("R7 one write clears", 8'h00, 32'h0);
    end

    // R6: general overflow
    fireOvf();
    chkReg("R6 overflow bit", 8'h00, 32'h0010_0000);
    check("R10 overflow irq", 32'(irq), 32'd1);
    doWrite(8'h00, 32'h0010_0000);

    // R10: mask x error matrix
    for (int i = 0; i < 5; i++) begin
      doWrite(8'h20, 32'(1) << i);
      for (int j = 0; j < 5; j++) begin
        if (j == 0) fireOvf();
        else fireDrop(j - 1, j % 4, j);
        check("R10 mask match", 32'(irq), 32'(i == j));
        doWrite(8'h00, 32'h01F0_0000);
        check("R10 cleared", 32'(irq), 32'd0);
      end
    end
    doWrite(8'h20, 32'h0);
    fireOvf();
    check("R10 all masked", 32'(irq), 32'd0);
    doWrite(8'h20, 32'h1F);

    // R8: set beats clear
    fireChan(5);
    @(negedge clk);
    regAddr = 8'h00; regWdata = 32'hFFFF_FFFF; regWrEn = 1'b1;
    chanAll[0] = 1'b1; dropEvt[3] = 1'b1; dropVc[7:6] = 2'd1; dropDt[23:18] = 6'd33;
    @(negedge clk);
    regWrEn = 1'b0; chanAll = '0; dropEvt = '0;
    expStat = 25'h100_0001;
    expDrop[3] = bump(expDrop[3], 1, 33);
    chkReg("R8 set wins", 8'h00, 32'h0100_0001);
    chkAll("R8 state");

    // R11: unmapped addresses
    doWrite(8'h04, 32'hFFFF_FFFF);
    doWrite(8'h18, 32'hFFFF_FFFF);
    doWrite(8'h24, 32'hFFFF_FFFF);
    doWrite(8'hFC, 32'hFFFF_FFFF);
    chkReg("R11 read hole", 8'h04, 32'h0);
    chkReg("R11 read hole", 8'h24, 32'h0);
    chkAll("R11 unchanged");

    summary();
    $finish;
  end

endmodule